// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Tracker

This block stands between a command scheduler and a four-bank SDRAM. On every clock cycle the scheduler presents at most one command (activate a row, read, write or precharge) together with a bank and a row address. The tracker answers in the same cycle with either a grant, meaning the command may go to the memory on this edge, or a stall, meaning the scheduler must hold the request and present it again. A stalled request is never discarded.

The tracker records, for each bank, whether a row is open and which row it is. It enforces three activation limits at the same time: the activate-to-access delay within a bank, the activate-to-activate interval within a bank, and the activate-to-activate interval between different banks. Each limit is a parameter in whole nanoseconds. Together with the clock period, it is converted at elaboration into a cycle count, rounding any fraction up.

Top module: `sdram_act_tracker`

## Requirements
- R1: Each timing limit becomes ceil(limit_ns / TCK_NS) cycles, with a minimum of 1. With the defaults (TCK_NS=8, TRCD_NS=20, TRC_NS=60, TRRD_NS=15) this gives 3, 8 and 2 cycles.
- R2: A read (code 2) or write (code 3) is granted only when its bank has an open row equal to `req_row`. Otherwise it is stalled.
- R3: A read or write to a bank is granted no earlier than the activate-to-access cycle count after the edge on which that bank's activate was granted. With the defaults, this is the third edge after the activate.
- R4: An activate (code 1) is stalled while its bank already has an open row.
- R5: Two granted activates to the same bank are at least the same-bank activate interval apart in cycles.
- R6: Two granted activates to any banks are at least the cross-bank activate interval apart in cycles.
- R7: A precharge (code 4) is always granted. It closes its bank from the next cycle on, and it may target a bank that is already closed.
- R8: Codes 0 and 5 to 7 are idle: neither grant nor stall is raised and no state changes. For codes 1 to 4, exactly one of grant and stall is high. A stalled command leaves all state unchanged and is granted once its limits are met.
- R9: After an activate is granted, `bank_open[b]` is set and `bank_row[b*ROW_W +: ROW_W]` holds the activated row until a precharge to bank b is granted.
- R10: While `rst_n` is low, all banks are closed and all timing counters are cleared. An activate presented right after reset is granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_cmd | input | 3 | Requested command: 0 idle, 1 activate, 2 read, 3 write, 4 precharge |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Row address for activate, read and write |
| grant | output | 1 | Command may issue on this edge |
| stall | output | 1 | Command must be held and presented again |
| bank_open | output | NB | One open flag per bank |
| bank_row | output | NB*ROW_W | Open row of each bank, bank b at bits b*ROW_W upward |

## Verification
The checker watches every cycle. It checks that grant and stall never both rise and that any real command raises one of them. It checks that granted reads and writes hit the bank's open row, that an activate never lands on an open bank, and that precharge and activate update the state outputs on the next cycle. It also keeps its own count of cycles since each activate, so it can flag any grant that comes too early.

The checker does not show that a grant comes as soon as it is allowed. It also does not show that the rounding produces the intended cycle counts. Those points, and how the tracker behaves after a reset in mid-run, are shown only by the bench's stall-then-grant sequences.

// File: rtl/act_pkg.sv
// Package: command codes and the nanosecond-to-cycle conversion used by the
// activation tracker. Assumes integer nanosecond limits and clock period.
package act_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    // Round a limit up to whole clock periods, never below one cycle.
    function automatic int ns_to_cyc(input int t_ns, input int tck_ns);
        int c;
        c = (t_ns + tck_ns - 1) / tck_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/act_bank_timer.sv
// Per-bank state: open flag, open row, and down-counters for the
// activate-to-access and activate-to-activate limits.
// Assumes act_go and pre_go are never high together.
module act_bank_timer #(
    parameter int ROW_W   = 13,
    parameter int RCD_CYC = 3,
    parameter int RC_CYC  = 8,
    parameter int CW      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rcd_done,
    output logic             rc_done
);

    logic [CW-1:0] rcd_cnt;
    logic [CW-1:0] rc_cnt;

    // Open flag and row capture on activate, clear on precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_row <= '0;
        end else if (act_go) begin
            is_open  <= 1'b1;
            open_row <= row_in;
        end else if (pre_go) begin
            is_open  <= 1'b0;
        end
    end

    // Load both counters on activate, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_cnt <= '0;
            rc_cnt  <= '0;
        end else if (act_go) begin
            rcd_cnt <= CW'(RCD_CYC - 1);
            rc_cnt  <= CW'(RC_CYC - 1);
        end else begin
            if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
            if (rc_cnt != '0)  rc_cnt  <= rc_cnt - 1'b1;
        end
    end

    assign rcd_done = (rcd_cnt == '0);
    assign rc_done  = (rc_cnt == '0);

endmodule

// File: rtl/act_rrd_timer.sv
// Shared counter for the minimum interval between activates to any banks.
// Assumes act_go pulses for one cycle on each granted activate.
module act_rrd_timer #(
    parameter int RRD_CYC = 2,
    parameter int CW      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    output logic done
);

    logic [CW-1:0] cnt;

    // Reload on any activate, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (act_go)     cnt <= CW'(RRD_CYC - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sdram_act_tracker.sv
// Top: decides in the same cycle whether the presented command may issue,
// and tracks open rows of NB banks. Assumes one request per cycle, held by the
// scheduler while stalled. Limits are integer ns, rounded up to cycles.
module sdram_act_tracker #(
    parameter int NB      = 4,
    parameter int ROW_W   = 13,
    parameter int TCK_NS  = 8,
    parameter int TRCD_NS = 20,
    parameter int TRC_NS  = 60,
    parameter int TRRD_NS = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            req_cmd,
    input  logic [1:0]            req_bank,
    input  logic [ROW_W-1:0]      req_row,
    output logic                  grant,
    output logic                  stall,
    output logic [NB-1:0]         bank_open,
    output logic [NB*ROW_W-1:0]   bank_row
);

    localparam int RCD_CYC = act_pkg::ns_to_cyc(TRCD_NS, TCK_NS);
    localparam int RC_CYC  = act_pkg::ns_to_cyc(TRC_NS, TCK_NS);
    localparam int RRD_CYC = act_pkg::ns_to_cyc(TRRD_NS, TCK_NS);
    localparam int MAX_CYC = act_pkg::max3(RCD_CYC, RC_CYC, RRD_CYC);
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [NB-1:0]    rcd_ok;
    logic [NB-1:0]    rc_ok;
    logic [ROW_W-1:0] row_q [NB];
    logic             rrd_ok;
    logic             act_grant;
    logic             pre_grant;
    logic             ok;
    logic             active;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            act_bank_timer #(
                .ROW_W(ROW_W), .RCD_CYC(RCD_CYC), .RC_CYC(RC_CYC), .CW(CW)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .act_go   (act_grant && (req_bank == b)),
                .pre_go   (pre_grant && (req_bank == b)),
                .row_in   (req_row),
                .is_open  (bank_open[b]),
                .open_row (row_q[b]),
                .rcd_done (rcd_ok[b]),
                .rc_done  (rc_ok[b])
            );
            assign bank_row[b*ROW_W +: ROW_W] = row_q[b];
        end
    endgenerate

    act_rrd_timer #(.RRD_CYC(RRD_CYC), .CW(CW)) u_rrd (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_go (act_grant),
        .done   (rrd_ok)
    );

    // Check the presented command against the selected bank's state and limits.
    always_comb begin
        active = 1'b1;
        ok     = 1'b0;
        case (req_cmd)
            act_pkg::CMD_ACT: ok = !bank_open[req_bank] && rc_ok[req_bank] && rrd_ok;
            act_pkg::CMD_RD,
            act_pkg::CMD_WR:  ok = bank_open[req_bank] && (row_q[req_bank] == req_row)
                                   && rcd_ok[req_bank];
            act_pkg::CMD_PRE: ok = 1'b1;
            default:          active = 1'b0;
        endcase
    end

    assign grant     = active && ok;
    assign stall     = active && !ok;
    assign act_grant = grant && (req_cmd == act_pkg::CMD_ACT);
    assign pre_grant = grant && (req_cmd == act_pkg::CMD_PRE);

endmodule

// File: rtl/act_tracker_checker.sv
// Checker bound to the tracker: counts cycles since each activate on its own
// and checks grants against the limits and the state outputs.
module act_tracker_checker #(
    parameter int NB      = 4,
    parameter int ROW_W   = 13,
    parameter int RCD_CYC = 3,
    parameter int RC_CYC  = 8,
    parameter int RRD_CYC = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          req_cmd,
    input logic [1:0]          req_bank,
    input logic [ROW_W-1:0]    req_row,
    input logic                grant,
    input logic                stall,
    input logic [NB-1:0]       bank_open,
    input logic [NB*ROW_W-1:0] bank_row
);

    logic [7:0]       since_bank [NB];
    logic [7:0]       since_any;
    logic [ROW_W-1:0] rows [NB];
    logic             g_act, g_acc, g_pre;

    assign g_act = grant && (req_cmd == 3'd1);
    assign g_acc = grant && (req_cmd == 3'd2 || req_cmd == 3'd3);
    assign g_pre = grant && (req_cmd == 3'd4);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_mon
            assign rows[b] = bank_row[b*ROW_W +: ROW_W];
            // Saturating cycle count since the last activate to this bank.
            always_ff @(posedge clk) begin
                if (!rst_n)                         since_bank[b] <= 8'hFF;
                else if (g_act && req_bank == b)    since_bank[b] <= 8'd1;
                else if (since_bank[b] != 8'hFF)    since_bank[b] <= since_bank[b] + 8'd1;
            end
        end
    endgenerate

    // Saturating cycle count since the last activate to any bank.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_any <= 8'hFF;
        else if (g_act)              since_any <= 8'd1;
        else if (since_any != 8'hFF) since_any <= since_any + 8'd1;
    end

    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && stall));
    assert_answer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd >= 3'd1 && req_cmd <= 3'd4) |-> (grant || stall));
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd == 3'd0 || req_cmd > 3'd4) |-> !(grant || stall));
    assert_acc_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        g_acc |-> (bank_open[req_bank] && rows[req_bank] == req_row));
    assert_acc_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        g_acc |-> (since_bank[req_bank] >= 8'(RCD_CYC)));
    assert_act_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        g_act |-> !bank_open[req_bank]);
    assert_same_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        g_act |-> (since_bank[req_bank] >= 8'(RC_CYC)));
    assert_any_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        g_act |-> (since_any >= 8'(RRD_CYC)));
    assert_pre_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        g_pre |=> !bank_open[$past(req_bank)]);
    assert_act_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        g_act |=> (bank_open[$past(req_bank)] && rows[$past(req_bank)] == $past(req_row)));
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (bank_open == '0));

endmodule

bind sdram_act_tracker act_tracker_checker #(
    .NB(NB), .ROW_W(ROW_W), .RCD_CYC(RCD_CYC), .RC_CYC(RC_CYC), .RRD_CYC(RRD_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_bank(req_bank),
    .req_row(req_row), .grant(grant), .stall(stall),
    .bank_open(bank_open), .bank_row(bank_row)
);

// File: tb/sdram_act_tracker_test.sv
// Bench: a vector table walked one cycle per entry, then directed checks.
module sdram_act_tracker_test;

    localparam int NV = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_cmd = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [12:0] req_row = '0;
    logic        grant, stall;
    logic [3:0]  bank_open;
    logic [51:0] bank_row;
    int          errors = 0;
    int          checks = 0;
    int          cycles = 0;

    // Each entry: cmd, bank, row, expected grant, expected stall.
    localparam logic [19:0] VEC [NV] = '{
        {3'd1, 2'd0, 13'd5, 1'b1, 1'b0},  // c0  act b0: granted
        {3'd2, 2'd0, 13'd5, 1'b0, 1'b1},  // c1  read too early (R3)
        {3'd1, 2'd1, 13'd7, 1'b1, 1'b0},  // c2  act b1 after 2 cycles (R6, R1)
        {3'd1, 2'd2, 13'd1, 1'b0, 1'b1},  // c3  act b2 too close (R6)
        {3'd2, 2'd0, 13'd5, 1'b1, 1'b0},  // c4  read b0 (R2, R3)
        {3'd3, 2'd1, 13'd7, 1'b1, 1'b0},  // c5  write b1 on third edge (R3, R1)
        {3'd4, 2'd0, 13'd0, 1'b1, 1'b0},  // c6  precharge b0 (R7)
        {3'd1, 2'd0, 13'd9, 1'b0, 1'b1},  // c7  act b0 before 8 cycles (R5)
        {3'd1, 2'd0, 13'd9, 1'b1, 1'b0},  // c8  act b0 at 8 cycles (R5, R1)
        {3'd2, 2'd0, 13'd9, 1'b0, 1'b1},  // c9  read early (R3)
        {3'd0, 2'd0, 13'd9, 1'b0, 1'b0},  // c10 idle (R8)
        {3'd2, 2'd0, 13'd9, 1'b1, 1'b0},  // c11 read granted (R3)
        {3'd2, 2'd1, 13'd8, 1'b0, 1'b1},  // c12 wrong row (R2)
        {3'd4, 2'd3, 13'd0, 1'b1, 1'b0},  // c13 precharge closed bank (R7)
        {3'd1, 2'd3, 13'd2, 1'b1, 1'b0},  // c14 act b3 (R6)
        {3'd1, 2'd2, 13'd1, 1'b0, 1'b1},  // c15 act b2 too close (R6)
        {3'd1, 2'd2, 13'd1, 1'b1, 1'b0}   // c16 act b2 (R6)
    };

    sdram_act_tracker uut (
        .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_bank(req_bank),
        .req_row(req_row), .grant(grant), .stall(stall),
        .bank_open(bank_open), .bank_row(bank_row)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic [12:0] r);
        @(negedge clk);
        req_cmd = c; req_bank = b; req_row = r;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(bank_open == 4'b0, "R10 banks closed in reset", bank_open, 0);
        check(!grant && !stall, "R10 no answer in reset", {grant, stall}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][19:17], VEC[i][16:15], VEC[i][14:2]);
            check(grant == VEC[i][1], $sformatf("R2-6 vector %0d grant", i), grant, VEC[i][1]);
            check(stall == VEC[i][0], $sformatf("R8 vector %0d stall", i), stall, VEC[i][0]);
        end
        drive(3'd0, 2'd0, 13'd0);
        check(bank_open == 4'b1111, "R9 all banks open", bank_open, 15);
        check(bank_row[12:0] == 13'd9,  "R9 bank0 row", bank_row[12:0], 9);
        check(bank_row[25:13] == 13'd7, "R9 bank1 row", bank_row[25:13], 7);
        check(bank_row[38:26] == 13'd1, "R9 bank2 row", bank_row[38:26], 1);
        check(bank_row[51:39] == 13'd2, "R9 bank3 row", bank_row[51:39], 2);

        // R4: activate on an open bank stalls repeatedly and changes nothing.
        for (int k = 0; k < 3; k++) begin
            drive(3'd1, 2'd0, 13'd3);
            check(stall && !grant, "R4 act on open bank stalls", stall, 1);
        end
        check(bank_row[12:0] == 13'd9, "R8 stalled act keeps row", bank_row[12:0], 9);
        drive(3'd6, 2'd1, 13'd4);
        check(!grant && !stall, "R8 unused code idle", {grant, stall}, 0);
        drive(3'd0, 2'd0, 13'd0);
        check(bank_open == 4'b1111, "R8 unused code no state change", bank_open, 15);
        drive(3'd4, 2'd0, 13'd0);
        drive(3'd1, 2'd0, 13'd3);
        check(grant, "R8 held act granted after precharge", grant, 1);
        drive(3'd0, 2'd0, 13'd0);
        check(bank_row[12:0] == 13'd3, "R9 new row stored", bank_row[12:0], 3);

        // R10: mid-run reset clears state and counters.
        drive(3'd1, 2'd1, 13'd0);
        @(negedge clk);
        req_cmd = 3'd0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(bank_open == 4'b0, "R10 banks closed after reset", bank_open, 0);
        drive(3'd1, 2'd0, 13'd11);
        check(grant, "R10 act granted right after reset", grant, 1);
        drive(3'd2, 2'd0, 13'd11);
        check(stall, "R10 read still early after act", stall, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule